// File: doc/BRIEF.md
# Pixel to Bus-Cycle Packer

This block sits between a pixel source and the strobe sequencer of a parallel display bus. It accepts pixels on a valid/ready stream, cuts each one into bus-width words and hands those words downstream on a second valid/ready stream. Every word it emits is marked as display data, which is the level the register-select line takes for data writes. Pixel size (12, 16, 18 or 24 bits) and bus width (8, 9, 12 or 16 lines) are chosen by two small codes. The block derives the number of bus cycles per pixel from them, and that includes a mode that fits two pixels into three bus cycles.

A transfer is armed by loading a pixel count (normally width times height) and pulsing a start input. The transfer then stays busy until the last bus word of the final pixel has been taken downstream. At that point the busy flag drops and a one-cycle frame-done pulse is raised. The configuration is captured at start, so the inputs may change while a frame is in flight. Pixel and word streams may both stall at any time without loss.

Top module: `pixel_bus_packer`

## Requirements
- R1: Size codes 0/1/2/3 select 12/16/18/24-bit pixels and width codes 0/1/2/3 select 8/9/12/16 lines. On a supported pair, a start pulse with a non-zero count raises `xfer_busy` on the next cycle, and `xfer_fmt` reports the format: 0 = one cycle per pixel, 1 = two, 2 = three, 3 = three cycles per two pixels.
- R2: The supported pairs are those whose pixel bits divided by lines is 1, 2 or 3, or whose ratio doubled is 3. A start pulse on any other pair is ignored: busy stays low, `pix_ready` stays low and no word is produced.
- R3: The pixels of a frame form one bit string: each pixel is taken MSB first and pixels follow in arrival order. Each bus word carries the next L bits of that string in `bus_word[L-1:0]`, with the earliest bit in bit L-1, and bits above L read zero. For example, a 16-bit pixel on 8 lines sends bits 15:8 and then 7:0, and a 24-bit pixel on 8 lines sends 23:16, then 15:8, then 7:0.
- R4: In the three-per-two format, word one is the top L bits of the first pixel. Word two holds the first pixel's low L/2 bits in its upper half and the second pixel's top L/2 bits in its lower half. Word three is the second pixel's low L bits.
- R5: In the three-per-two format with an odd count, the frame ends with one extra word. Its upper half is the last pixel's low L/2 bits and its lower half is zero, so a frame of N pixels yields ceil(3N/2) words.
- R6: In the other formats a frame of N pixels yields exactly N times the cycles-per-pixel words.
- R7: `frame_done` is high for exactly one cycle, in the cycle after the final word handshake. `xfer_busy` is low in that same cycle.
- R8: While `bus_valid` is high and `bus_ready` low, the word is held unchanged. No word is dropped or repeated.
- R9: Pixel input bits above the selected pixel size have no effect on the words.
- R10: A start pulse during a busy transfer is ignored. Changes to the size, width and count inputs during a transfer do not affect it.
- R11: A start pulse with a pixel count of zero is ignored.
- R12: While idle, `pix_ready` and `bus_valid` are low. A transfer accepts exactly the programmed number of pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pix_size | input | 2 | Pixel size code |
| cfg_bus_width | input | 2 | Bus width code |
| cfg_pix_count | input | CNT_W | Pixels in the frame |
| xfer_start | input | 1 | Start pulse |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_fmt | output | 2 | Cycle format of the current transfer |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel accepted when valid |
| pix_data | input | 24 | Pixel, right-aligned |
| bus_valid | output | 1 | Bus word offered |
| bus_ready | input | 1 | Downstream takes the word |
| bus_word | output | 16 | Bus word, right-aligned |
| bus_is_data | output | 1 | Word is display data |

## Verification
The bench builds the block with a six-bit pixel count. This makes the all-ones count of 63 pixels short enough to run, so a full-scale frame in the three-cycle format (189 words) is covered together with counter exhaustion. Every supported size and width pair is run, including odd and even counts in the three-per-two mode. The runs use stalls on both streams, pixels with noise above the pixel size, and configuration changes plus a second start in the middle of a frame.

// File: rtl/pxpk_pkg.sv
package pxpk_pkg;
    // Widest pixel and widest bus the codes can select.
    localparam int PIX_MAX = 24;
    localparam int BUS_MAX = 16;
    // Accumulator holds a partial word plus one whole pixel.
    localparam int ACC_W   = 2 * PIX_MAX;
    localparam int FILL_W  = $clog2(ACC_W + 1);

    typedef enum logic [1:0] {
        FMT_ONE   = 2'd0,
        FMT_TWO   = 2'd1,
        FMT_THREE = 2'd2,
        FMT_3FOR2 = 2'd3
    } cyc_fmt_e;
endpackage

// File: rtl/fmt_decode.sv
// fmt_decode: turns size and width codes into bit counts and a cycle format.
// Assumes the code tables of the brief; flags pairs that fit no format.
module fmt_decode
    import pxpk_pkg::*;
(
    input  logic [1:0]        size_code,
    input  logic [1:0]        width_code,
    output cyc_fmt_e          fmt,
    output logic              fmt_ok,
    output logic [FILL_W-1:0] pix_bits,
    output logic [FILL_W-1:0] line_bits
);
    logic [FILL_W+1:0] p_x, l_x;

    // Code to bit count lookup.
    always_comb begin
        case (size_code)
            2'd0:    pix_bits = FILL_W'(12);
            2'd1:    pix_bits = FILL_W'(16);
            2'd2:    pix_bits = FILL_W'(18);
            default: pix_bits = FILL_W'(24);
        endcase
        case (width_code)
            2'd0:    line_bits = FILL_W'(8);
            2'd1:    line_bits = FILL_W'(9);
            2'd2:    line_bits = FILL_W'(12);
            default: line_bits = FILL_W'(16);
        endcase
    end

    assign p_x = {2'b00, pix_bits};
    assign l_x = {2'b00, line_bits};

    // Ratio test picks the format.
    always_comb begin
        fmt_ok = 1'b1;
        if (p_x == l_x)                fmt = FMT_ONE;
        else if (p_x == (l_x << 1))    fmt = FMT_TWO;
        else if (p_x == l_x * 3)       fmt = FMT_THREE;
        else if ((p_x << 1) == l_x * 3) fmt = FMT_3FOR2;
        else begin
            fmt    = FMT_ONE;
            fmt_ok = 1'b0;
        end
    end
endmodule

// File: rtl/xfer_ctrl.sv
// xfer_ctrl: arms a frame on start, captures the configuration, counts
// pixels down and ends the frame with a single done pulse.
// Assumes last_word is only asserted on a real final word handshake.
module xfer_ctrl
    import pxpk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_ok,
    input  logic [1:0]       size_in,
    input  logic [1:0]       width_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             pix_fire,
    input  logic             last_word,
    output logic             busy,
    output logic             done,
    output logic             more_pix,
    output logic             arm,
    output logic [1:0]       size_q,
    output logic [1:0]       width_q
);
    logic [CNT_W-1:0] left_q;

    assign arm      = start && !busy && cfg_ok && (count_in != '0);
    assign more_pix = (left_q != '0);

    // Busy flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                busy <= 1'b1;
            end else if (busy && last_word) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // Configuration capture and remaining pixel count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            size_q  <= '0;
            width_q <= '0;
        end else if (arm) begin
            left_q  <= count_in;
            size_q  <= size_in;
            width_q <= width_in;
        end else if (pix_fire) begin
            left_q  <= left_q - 1'b1;
        end
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last_word) |=> (busy && $stable(size_q) && $stable(width_q)));
    p_zero_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count_in == '0) |=> !busy);
    p_bad_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !cfg_ok) |=> !busy);
endmodule

// File: rtl/bit_packer.sv
// bit_packer: left-aligned bit accumulator. Pixels are appended below the
// bits already held; words are taken from the top, L bits at a time.
// Assumes pix_bits and line_bits stay fixed while active is high.
module bit_packer
    import pxpk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                active,
    input  logic                more_pix,
    input  logic [FILL_W-1:0]   pix_bits,
    input  logic [FILL_W-1:0]   line_bits,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [PIX_MAX-1:0]  in_pix,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [BUS_MAX-1:0]  out_word,
    output logic                last_word
);
    logic [ACC_W-1:0]   acc;
    logic [FILL_W-1:0]  fill;
    logic [PIX_MAX-1:0] pmask, masked;
    logic [ACC_W-1:0]   aligned, insert;
    logic [BUS_MAX-1:0] top_bits;
    logic               in_fire, out_fire;

    // Pixel masking and placement under the held bits.
    always_comb begin
        pmask   = {PIX_MAX{1'b1}} >> (FILL_W'(PIX_MAX) - pix_bits);
        masked  = in_pix & pmask;
        aligned = {masked, {PIX_MAX{1'b0}}} << (FILL_W'(PIX_MAX) - pix_bits);
        insert  = aligned >> fill;
    end

    assign top_bits  = acc[ACC_W-1 -: BUS_MAX];
    assign out_word  = out_valid ? (top_bits >> (FILL_W'(BUS_MAX) - line_bits)) : '0;
    assign in_ready  = active && more_pix && (fill < line_bits);
    assign out_valid = active && ((fill >= line_bits) || (!more_pix && fill != '0));
    assign last_word = out_fire && !more_pix && (fill <= line_bits);
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;

    // Accumulator update: append a pixel or retire a word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc  <= '0;
            fill <= '0;
        end else if (in_fire) begin
            acc  <= acc | insert;
            fill <= fill + pix_bits;
        end else if (out_fire) begin
            acc  <= acc << line_bits;
            fill <= (fill > line_bits) ? (fill - line_bits) : '0;
        end
    end

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
    p_tail_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_word |=> !out_valid);
    p_fill_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |=> (fill <= FILL_W'(BUS_MAX + PIX_MAX)));
endmodule

// File: rtl/pixel_bus_packer.sv
// pixel_bus_packer: top level. Decodes the live configuration to vet a
// start, decodes the captured configuration to drive the datapath, and
// joins the controller and the accumulator.
// Assumes pixels arrive right-aligned on pix_data.
module pixel_bus_packer
    import pxpk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_pix_size,
    input  logic [1:0]         cfg_bus_width,
    input  logic [CNT_W-1:0]   cfg_pix_count,
    input  logic               xfer_start,
    output logic               xfer_busy,
    output logic [1:0]         xfer_fmt,
    output logic               frame_done,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic [PIX_MAX-1:0] pix_data,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic [BUS_MAX-1:0] bus_word,
    output logic               bus_is_data
);
    cyc_fmt_e          live_fmt, run_fmt;
    logic              live_ok, run_ok;
    logic [FILL_W-1:0] live_p, live_l, run_p, run_l;
    logic [1:0]        size_q, width_q;
    logic              more_pix, arm, last_word;

    fmt_decode u_live_dec (
        .size_code(cfg_pix_size), .width_code(cfg_bus_width),
        .fmt(live_fmt), .fmt_ok(live_ok), .pix_bits(live_p), .line_bits(live_l)
    );

    fmt_decode u_run_dec (
        .size_code(size_q), .width_code(width_q),
        .fmt(run_fmt), .fmt_ok(run_ok), .pix_bits(run_p), .line_bits(run_l)
    );

    xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .cfg_ok(live_ok),
        .size_in(cfg_pix_size), .width_in(cfg_bus_width), .count_in(cfg_pix_count),
        .pix_fire(pix_valid && pix_ready), .last_word(last_word),
        .busy(xfer_busy), .done(frame_done), .more_pix(more_pix), .arm(arm),
        .size_q(size_q), .width_q(width_q)
    );

    bit_packer u_pack (
        .clk(clk), .rst_n(rst_n), .clear(arm), .active(xfer_busy && run_ok),
        .more_pix(more_pix), .pix_bits(run_p), .line_bits(run_l),
        .in_valid(pix_valid), .in_ready(pix_ready), .in_pix(pix_data),
        .out_valid(bus_valid), .out_ready(bus_ready), .out_word(bus_word),
        .last_word(last_word)
    );

    assign xfer_fmt    = run_fmt;
    assign bus_is_data = bus_valid;

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> (!pix_ready && !bus_valid));
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> xfer_busy);
    p_live_p_used_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (run_p == $past(live_p) && run_l == $past(live_l)));
endmodule

// File: tb/pixel_bus_packer_test.sv
`timescale 1ns/1ps
module pixel_bus_packer_test;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       cfg_pix_size = '0;
    logic [1:0]       cfg_bus_width = '0;
    logic [CNT_W-1:0] cfg_pix_count = '0;
    logic             xfer_start = 1'b0;
    logic             xfer_busy;
    logic [1:0]       xfer_fmt;
    logic             frame_done;
    logic             pix_valid = 1'b0;
    logic             pix_ready;
    logic [23:0]      pix_data = '0;
    logic             bus_valid;
    logic             bus_ready = 1'b0;
    logic [15:0]      bus_word;
    logic             bus_is_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    logic [15:0] got [0:255];
    int got_n;

    always #4 clk = ~clk;

    pixel_bus_packer #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_pix_size(cfg_pix_size),
        .cfg_bus_width(cfg_bus_width), .cfg_pix_count(cfg_pix_count),
        .xfer_start(xfer_start), .xfer_busy(xfer_busy), .xfer_fmt(xfer_fmt),
        .frame_done(frame_done), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_data(pix_data), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_word(bus_word), .bus_is_data(bus_is_data)
    );

    // Watchdog: a hung run counts as one failure.
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc_total);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Pixel stream with noise in all 24 bits.
    function automatic logic [23:0] pix_val(input int i);
        logic [31:0] h;
        h = i * 32'h9E3779B1 + 32'h01234567;
        return h[27:4] ^ {h[7:0], h[31:16]};
    endfunction

    function automatic int size_bits(input logic [1:0] c);
        case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
    endfunction

    function automatic int width_bits(input logic [1:0] c);
        case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
    endfunction

    // Word j of the MSB-first string of N pixels of P bits, cut in L-bit words.
    function automatic logic [15:0] exp_word(input int j, input int p, input int l, input int n);
        logic [15:0] w;
        logic [23:0] px;
        w = '0;
        for (int i = 0; i < l; i++) begin
            int b, pi, off;
            b = j * l + i;
            pi = b / p;
            off = p - 1 - (b % p);
            if (pi < n) begin
                px = pix_val(pi);
                w[l - 1 - i] = px[off];
            end
        end
        return w;
    endfunction

    function automatic bit pat(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return (c % 3) != 0;
            default: return ((c * 7) % 5) < 2;
        endcase
    endfunction

    // Runs one frame and checks count, content, done timing and busy.
    task automatic run_frame(input logic [1:0] psz, input logic [1:0] bw, input int n,
                             input logic [1:0] fmt_exp, input int rmode, input int vmode,
                             input bit disturb);
        int p, l, sent, cyc, last_fire, exp_n, bad_words, first_bad;
        bit seen_done;
        p = size_bits(psz);
        l = width_bits(bw);
        exp_n = (n * p + l - 1) / l;
        got_n = 0; sent = 0; last_fire = -10; bad_words = 0; first_bad = -1;
        seen_done = 1'b0;
        @(negedge clk);
        cfg_pix_size = psz; cfg_bus_width = bw; cfg_pix_count = CNT_W'(n);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(xfer_busy === 1'b1, "R1 busy after start", {31'd0, xfer_busy}, 1);
        chk(xfer_fmt === fmt_exp, "R1 format code", {30'd0, xfer_fmt}, {30'd0, fmt_exp});
        for (cyc = 0; cyc < 4000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (frame_done) begin
                seen_done = 1'b1;
                break;
            end
            bus_ready = pat(rmode, cyc);
            pix_valid = (sent < n) && pat(vmode, cyc + 1);
            pix_data = pix_val(sent);
            if (disturb && cyc == 3) begin
                cfg_pix_size = ~psz; cfg_bus_width = ~bw; cfg_pix_count = CNT_W'(1);
                xfer_start = 1'b1;
            end else begin
                xfer_start = 1'b0;
            end
            if (bus_valid && bus_ready) begin
                if (!bus_is_data) bad_words++;
                if (got_n < 256) got[got_n] = bus_word;
                got_n++;
                last_fire = cyc;
            end
            if (pix_valid && pix_ready) sent++;
        end
        pix_valid = 1'b0; bus_ready = 1'b0; xfer_start = 1'b0;
        chk(seen_done, "R7 frame_done seen", {31'd0, seen_done}, 1);
        chk(cyc == last_fire + 1, "R7 done one cycle after last word", cyc, last_fire + 1);
        chk(!xfer_busy, "R7 busy low with done", {31'd0, xfer_busy}, 0);
        chk(sent == n, "R12 pixels accepted", sent, n);
        chk(got_n == exp_n, "R6/R5 word count", got_n, exp_n);
        for (int j = 0; j < got_n && j < 256; j++) begin
            if (got[j] !== exp_word(j, p, l, n)) begin
                if (first_bad < 0) first_bad = j;
                bad_words++;
            end
        end
        if (first_bad >= 0)
            chk(1'b0, "R3/R9 word content", {16'd0, got[first_bad]},
                {16'd0, exp_word(first_bad, p, l, n)});
        else
            chk(bad_words == 0, "R3/R9 word content", bad_words, 0);
        @(negedge clk);
        chk(!frame_done, "R7 done single cycle", {31'd0, frame_done}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!xfer_busy && !frame_done, "R12 reset idle", {30'd0, xfer_busy, frame_done}, 0);
        chk(!pix_ready && !bus_valid, "R12 reset quiet", {30'd0, pix_ready, bus_valid}, 0);
    endtask

    task automatic t_order_16_on_8();
        logic [23:0] p0;
        run_frame(2'd1, 2'd0, 5, 2'd1, 0, 0, 1'b0);
        p0 = pix_val(0);
        chk(got[0] === {8'd0, p0[15:8]}, "R3 16on8 high byte first", got[0], p0[15:8]);
        chk(got[1] === {8'd0, p0[7:0]}, "R3 16on8 low byte second", got[1], p0[7:0]);
    endtask

    task automatic t_order_24_on_8();
        logic [23:0] p0;
        run_frame(2'd3, 2'd0, 7, 2'd2, 1, 2, 1'b0);
        p0 = pix_val(0);
        chk(got[0] === {8'd0, p0[23:16]} && got[1] === {8'd0, p0[15:8]} &&
            got[2] === {8'd0, p0[7:0]}, "R3 24on8 byte order", {got[0][7:0], got[1][7:0], got[2][7:0]}, p0);
    endtask

    task automatic t_three_for_two();
        logic [23:0] a, b;
        run_frame(2'd0, 2'd0, 4, 2'd3, 2, 1, 1'b0);
        a = pix_val(0); b = pix_val(1);
        chk(got[0] === {8'd0, a[11:4]}, "R4 word one", got[0], a[11:4]);
        chk(got[1] === {8'd0, a[3:0], b[11:8]}, "R4 word two", got[1], {a[3:0], b[11:8]});
        chk(got[2] === {8'd0, b[7:0]}, "R4 word three", got[2], b[7:0]);
        run_frame(2'd2, 2'd2, 6, 2'd3, 1, 0, 1'b0);
        run_frame(2'd3, 2'd3, 8, 2'd3, 0, 2, 1'b0);
    endtask

    task automatic t_odd_tail();
        logic [23:0] c;
        run_frame(2'd0, 2'd0, 3, 2'd3, 0, 0, 1'b0);
        c = pix_val(2);
        chk(got[4] === {8'd0, c[3:0], 4'd0}, "R5 padded tail word", got[4], {c[3:0], 4'd0});
        run_frame(2'd3, 2'd3, 5, 2'd3, 2, 2, 1'b0);
    endtask

    task automatic t_other_formats();
        run_frame(2'd0, 2'd2, 9, 2'd0, 1, 1, 1'b0);
        run_frame(2'd1, 2'd3, 4, 2'd0, 2, 0, 1'b0);
        run_frame(2'd2, 2'd1, 6, 2'd1, 0, 1, 1'b0);
        run_frame(2'd3, 2'd2, 5, 2'd1, 2, 2, 1'b0);
    endtask

    task automatic t_refused(input logic [1:0] psz, input logic [1:0] bw, input int n,
                             input string tag);
        int moved;
        moved = 0;
        @(negedge clk);
        cfg_pix_size = psz; cfg_bus_width = bw; cfg_pix_count = CNT_W'(n);
        xfer_start = 1'b1; pix_valid = 1'b1; bus_ready = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (xfer_busy || pix_ready || bus_valid) moved++;
            @(negedge clk);
        end
        pix_valid = 1'b0; bus_ready = 1'b0;
        chk(moved == 0, tag, moved, 0);
    endtask

    task automatic t_disturb();
        run_frame(2'd1, 2'd0, 6, 2'd1, 1, 1, 1'b1); // R10 restart and config change mid-frame
    endtask

    task automatic t_full_count();
        run_frame(2'd3, 2'd0, 63, 2'd2, 2, 1, 1'b0); // R6 full-scale count
    endtask

    initial begin
        t_reset();
        t_order_16_on_8();
        t_order_24_on_8();
        t_three_for_two();
        t_odd_tail();
        t_other_formats();
        t_refused(2'd0, 2'd1, 4, "R2 12 bits on 9 lines refused");
        t_refused(2'd3, 2'd1, 4, "R2 24 bits on 9 lines refused");
        t_refused(2'd1, 2'd2, 4, "R2 16 bits on 12 lines refused");
        t_refused(2'd1, 2'd3, 0, "R11 zero count refused");
        t_disturb();
        t_full_count();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule